// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the entry step for exceptions in a small 32-bit RISC core. When the core presents a request with a cause code, the block works out the handler fetch address, decides which link register receives the interrupted program counter, and computes the new interrupt-enable state. All of these appear together one clock after the request. The register file, the pipeline flush and the return instructions are outside the block. The block drives only a write port for the link register, the next enable state and the next fetch address.

There are two classes of cause. Ordinary faults, interrupts and system calls save the program counter in the exception link register and keep the old global enable in an exception shadow bit. Breakpoints and watchpoints save it in the breakpoint link register and keep the old enable in a breakpoint shadow bit. Handler slots are 32 bytes apart and start from a 256-byte-aligned base. Debug causes always use the debug base. A remap control sends ordinary causes to the debug base as well.

Top module: `exc_entry_ctrl`

## Requirements
- R1: For an ordinary cause (2 instruction bus error, 4 data bus error, 5 divide by zero, 6 interrupt, 7 system call), the result has `link_we`=1, `link_sel`=0 (exception link register) and `link_data` equal to the requesting `cur_pc`.
- R2: On ordinary entry, `next_ie` is formed as follows: bit 1 (exception shadow) takes the old bit 0 (global enable), bit 0 is cleared, and bit 2 (breakpoint shadow) is kept.
- R3: `next_pc` is the selected base with its low 8 bits dropped, joined with the cause in bits 7:5 and zeros in bits 4:0. This equals base + cause*32 for an aligned base.
- R4: For ordinary causes the base is `dbg_base` when `remap_to_dbg`=1, and `exc_base` otherwise.
- R5: For a debug cause (1 breakpoint, 3 watchpoint), the result has `link_we`=1, `link_sel`=1 (breakpoint link register) and `link_data` equal to `cur_pc`.
- R6: On debug entry, `next_ie` bit 2 takes the old bit 0, bit 0 is cleared, and bit 1 is kept.
- R7: Debug causes always take their base from `dbg_base`, whatever the value of `remap_to_dbg`.
- R8: Any other cause code (0, which is reserved for reset, and 8 to 15) sets `cause_err`=1 and `link_we`=0. It also makes `next_pc` equal `cur_pc` and `next_ie` equal `cur_ie`, and it leaves `link_sel` and `link_data` unchanged.
- R9: A request sampled on a clock edge shows its result (with `take_valid`=1) right after that edge. A cycle without a request gives `take_valid`=0, `link_we`=0 and `cause_err`=0, and all other outputs hold their values.
- R10: While `rst` is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request this cycle |
| req_cause | input | 4 | Cause code |
| cur_pc | input | 32 | Program counter of the interrupted instruction |
| cur_ie | input | 3 | Current enable state: bit0 global, bit1 exception shadow, bit2 breakpoint shadow |
| exc_base | input | 32 | Ordinary handler base (low 8 bits ignored) |
| dbg_base | input | 32 | Debug handler base (low 8 bits ignored) |
| remap_to_dbg | input | 1 | Send ordinary causes to the debug base |
| take_valid | output | 1 | Result valid this cycle |
| next_pc | output | 32 | New fetch address |
| next_ie | output | 3 | New enable state |
| link_we | output | 1 | Link register write enable |
| link_sel | output | 1 | 0 exception link register, 1 breakpoint link register |
| link_data | output | 32 | Value written to the link register |
| cause_err | output | 1 | Unsupported cause code |

## Verification
The bench gives the base inputs non-zero low bits. A design that added the base and the offset arithmetically, instead of joining the fields, would produce the wrong slot addresses. It sets the shadow bits against the global bit, so a design that swapped the two shadow bits, or cleared the shadow bit it should keep, would show a wrong `next_ie`. It applies remap with both classes of cause, which catches a design that lets remap move debug causes or ignores remap for ordinary ones. It also sends cause 0 and codes above 7, where a faulty design would write a link register or jump.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    // Cause codes (the slot index is the code itself)
    localparam int CODE_RESET   = 0;
    localparam int CODE_BREAK   = 1;
    localparam int CODE_IBUS    = 2;
    localparam int CODE_WATCH   = 3;
    localparam int CODE_DBUS    = 4;
    localparam int CODE_DIVZERO = 5;
    localparam int CODE_IRQ     = 6;
    localparam int CODE_SYSCALL = 7;

    typedef enum logic [1:0] {
        CLS_ORDINARY = 2'd0,
        CLS_DEBUG    = 2'd1,
        CLS_BAD      = 2'd2
    } entry_class_e;

    typedef enum logic {
        LINK_EXC = 1'b0,
        LINK_BRK = 1'b1
    } link_target_e;

    typedef struct packed {
        logic brk_shadow;   // bit 2
        logic exc_shadow;   // bit 1
        logic global_en;    // bit 0
    } enable_state_t;

    function automatic enable_state_t enter_enable(enable_state_t cur, logic to_debug);
        enable_state_t nxt;
        nxt = cur;
        nxt.global_en = 1'b0;
        if (to_debug) nxt.brk_shadow = cur.global_en;
        else          nxt.exc_shadow = cur.global_en;
        return nxt;
    endfunction

endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
    import exc_entry_pkg::*;
#(
    parameter int CAUSE_W = 4,
    parameter int IDX_W   = 3
) (
    input  logic [CAUSE_W-1:0] cause,
    output entry_class_e       cls,
    output logic [IDX_W-1:0]   slot
);
    always_comb begin
        case (cause)
            CAUSE_W'(CODE_BREAK), CAUSE_W'(CODE_WATCH):
                cls = CLS_DEBUG;
            CAUSE_W'(CODE_IBUS), CAUSE_W'(CODE_DBUS), CAUSE_W'(CODE_DIVZERO),
            CAUSE_W'(CODE_IRQ), CAUSE_W'(CODE_SYSCALL):
                cls = CLS_ORDINARY;
            default:
                cls = CLS_BAD;
        endcase
        slot = cause[IDX_W-1:0];
    end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IDX_W      = 3,
    parameter int SLOT_SHIFT = 5
) (
    input  entry_class_e     cls,
    input  logic             remap,
    input  logic [XLEN-1:0]  base_exc,
    input  logic [XLEN-1:0]  base_dbg,
    input  logic [IDX_W-1:0] slot,
    output logic [XLEN-1:0]  vector
);
    localparam int BASE_LSB = SLOT_SHIFT + IDX_W;

    logic [XLEN-1:0] base_sel;

    always_comb begin
        base_sel = (cls == CLS_DEBUG || remap) ? base_dbg : base_exc;
        vector   = {base_sel[XLEN-1:BASE_LSB], slot, {SLOT_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int CAUSE_W    = 4,
    parameter int IDX_W      = 3,
    parameter int SLOT_SHIFT = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [CAUSE_W-1:0] req_cause,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [2:0]         cur_ie,
    input  logic [XLEN-1:0]    exc_base,
    input  logic [XLEN-1:0]    dbg_base,
    input  logic               remap_to_dbg,
    output logic               take_valid,
    output logic [XLEN-1:0]    next_pc,
    output logic [2:0]         next_ie,
    output logic               link_we,
    output logic               link_sel,
    output logic [XLEN-1:0]    link_data,
    output logic               cause_err
);
    localparam int BASE_LSB = SLOT_SHIFT + IDX_W;

    entry_class_e     cls;
    logic [IDX_W-1:0] slot;
    logic [XLEN-1:0]  vector;
    enable_state_t    ie_now;
    enable_state_t    ie_new;
    logic             is_bad;
    logic             is_dbg;

    exc_cause_decode #(.CAUSE_W(CAUSE_W), .IDX_W(IDX_W)) u_decode (
        .cause (req_cause),
        .cls   (cls),
        .slot  (slot)
    );

    exc_vector_gen #(.XLEN(XLEN), .IDX_W(IDX_W), .SLOT_SHIFT(SLOT_SHIFT)) u_vector (
        .cls      (cls),
        .remap    (remap_to_dbg),
        .base_exc (exc_base),
        .base_dbg (dbg_base),
        .slot     (slot),
        .vector   (vector)
    );

    always_comb begin
        ie_now = enable_state_t'(cur_ie);
        is_bad = (cls == CLS_BAD);
        is_dbg = (cls == CLS_DEBUG);
        ie_new = enter_enable(ie_now, is_dbg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take_valid <= 1'b0;
            link_we    <= 1'b0;
            cause_err  <= 1'b0;
            next_pc    <= '0;
            next_ie    <= '0;
            link_sel   <= LINK_EXC;
            link_data  <= '0;
        end else begin
            take_valid <= req_valid;
            link_we    <= req_valid && !is_bad;
            cause_err  <= req_valid && is_bad;
            if (req_valid) begin
                if (is_bad) begin
                    next_pc <= cur_pc;
                    next_ie <= cur_ie;
                end else begin
                    next_pc   <= vector;
                    next_ie   <= ie_new;
                    link_sel  <= is_dbg ? LINK_BRK : LINK_EXC;
                    link_data <= cur_pc;
                end
            end
        end
    end

    // Error result never writes a link register
    assert_err_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        cause_err |-> (!link_we && take_valid));

    // Error result keeps the program counter of the request
    assert_err_keeps_pc_R8: assert property (@(posedge clk) disable iff (rst)
        cause_err |-> (next_pc == $past(cur_pc)));

    // Every accepted entry masks the global enable
    assert_entry_masks_R2: assert property (@(posedge clk) disable iff (rst)
        (take_valid && !cause_err) |-> !next_ie[0]);

    // One-cycle latency for requests
    assert_req_latency_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> take_valid);

    // Idle cycle produces no result
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!take_valid && !link_we && !cause_err));

    // Vector lands on a slot boundary
    assert_slot_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (next_pc[SLOT_SHIFT-1:0] == '0));

    // Debug entries always come from the debug base
    assert_debug_base_R7: assert property (@(posedge clk) disable iff (rst)
        (link_we && link_sel) |-> (next_pc[XLEN-1:BASE_LSB] == $past(dbg_base[XLEN-1:BASE_LSB])));

endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [3:0]  req_cause;
    logic [31:0] cur_pc;
    logic [2:0]  cur_ie;
    logic [31:0] exc_base;
    logic [31:0] dbg_base;
    logic        remap_to_dbg;
    logic        take_valid;
    logic [31:0] next_pc;
    logic [2:0]  next_ie;
    logic        link_we;
    logic        link_sel;
    logic [31:0] link_data;
    logic        cause_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cause(req_cause),
        .cur_pc(cur_pc), .cur_ie(cur_ie), .exc_base(exc_base), .dbg_base(dbg_base),
        .remap_to_dbg(remap_to_dbg), .take_valid(take_valid), .next_pc(next_pc),
        .next_ie(next_ie), .link_we(link_we), .link_sel(link_sel),
        .link_data(link_data), .cause_err(cause_err)
    );

    typedef struct {
        logic        valid;
        logic        we;
        logic        sel;
        logic [31:0] data;
        logic [31:0] pc;
        logic [2:0]  ie;
        logic        err;
        string       tag;
    } expect_t;

    expect_t     sb_q[$];
    int          n_checks = 0;
    int          n_fails  = 0;
    logic        mon_on   = 1'b0;
    logic [31:0] m_pc   = '0;
    logic [2:0]  m_ie   = '0;
    logic        m_sel  = 1'b0;
    logic [31:0] m_data = '0;

    task automatic send(input logic v, input logic [3:0] c, input logic [31:0] pc,
                        input logic [2:0] ie, input logic [31:0] eb, input logic [31:0] db,
                        input logic rm, input string tag);
        expect_t e;
        logic    dbg, ord;
        @(negedge clk);
        req_valid = v; req_cause = c; cur_pc = pc; cur_ie = ie;
        exc_base = eb; dbg_base = db; remap_to_dbg = rm;
        dbg = (c == 4'd1) || (c == 4'd3);
        ord = (c == 4'd2) || (c == 4'd4) || (c == 4'd5) || (c == 4'd6) || (c == 4'd7);
        e.valid = v; e.we = v && (dbg || ord); e.err = v && !(dbg || ord); e.tag = tag;
        if (v) begin
            if (dbg || ord) begin
                m_pc   = (((dbg || rm) ? db : eb) & 32'hFFFF_FF00) + {28'd0, c} * 32;
                m_ie   = dbg ? {ie[0], ie[1], 1'b0} : {ie[2], ie[0], 1'b0};
                m_sel  = dbg;
                m_data = pc;
            end else begin
                m_pc = pc;
                m_ie = ie;
            end
        end
        e.pc = m_pc; e.ie = m_ie; e.sel = m_sel; e.data = m_data;
        sb_q.push_back(e);
    endtask

    initial begin : monitor
        expect_t e;
        forever begin
            @(posedge clk);
            #1;
            if (mon_on && sb_q.size() > 0) begin
                e = sb_q.pop_front();
                n_checks++;
                if (take_valid !== e.valid || link_we !== e.we || cause_err !== e.err ||
                    next_pc !== e.pc || next_ie !== e.ie || link_sel !== e.sel ||
                    link_data !== e.data) begin
                    n_fails++;
                    $display("FAIL %s: got v=%b we=%b err=%b pc=%h ie=%b sel=%b data=%h exp v=%b we=%b err=%b pc=%h ie=%b sel=%b data=%h",
                        e.tag, take_valid, link_we, cause_err, next_pc, next_ie, link_sel, link_data,
                        e.valid, e.we, e.err, e.pc, e.ie, e.sel, e.data);
                end
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : driver
        rst = 1'b1; req_valid = 1'b0; req_cause = '0; cur_pc = '0; cur_ie = '0;
        exc_base = '0; dbg_base = '0; remap_to_dbg = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (take_valid !== 1'b0 || link_we !== 1'b0 || cause_err !== 1'b0 || next_pc !== '0 ||
            next_ie !== '0 || link_sel !== 1'b0 || link_data !== '0) begin
            n_fails++;
            $display("FAIL R10: got v=%b we=%b err=%b pc=%h ie=%b exp all zero",
                     take_valid, link_we, cause_err, next_pc, next_ie);
        end
        rst = 1'b0;
        mon_on = 1'b1;

        send(1'b0, 4'd0, 32'h0, 3'b000, 32'h0, 32'h0, 1'b0, "R9 idle");
        send(1'b1, 4'd2, 32'h0000_1234, 3'b001, 32'h1000_00A5, 32'h2000_0000, 1'b0, "R1 R2 R3 R4 ibus");
        send(1'b1, 4'd4, 32'h0000_2000, 3'b110, 32'h1000_00FF, 32'h2000_0000, 1'b0, "R2 R3 dbus shadow");
        send(1'b1, 4'd5, 32'h0000_3004, 3'b011, 32'hABCD_EF11, 32'h2000_0000, 1'b0, "R1 R3 divzero");
        send(1'b1, 4'd6, 32'h0000_4008, 3'b101, 32'h1000_0000, 32'h2000_0080, 1'b1, "R4 irq remap");
        send(1'b1, 4'd7, 32'h0000_500C, 3'b001, 32'h1000_0000, 32'h2000_0000, 1'b1, "R4 syscall remap");
        send(1'b1, 4'd1, 32'h0000_6010, 3'b001, 32'h1000_0000, 32'h3000_0033, 1'b0, "R5 R6 R7 break");
        send(1'b1, 4'd3, 32'h0000_7014, 3'b011, 32'h1000_0000, 32'h3000_0000, 1'b1, "R5 R6 R7 watch remap");
        send(1'b1, 4'd3, 32'h0000_7018, 3'b100, 32'h1000_0000, 32'h3000_0000, 1'b0, "R6 watch no enable");
        send(1'b0, 4'd2, 32'h0000_9999, 3'b111, 32'h1000_0000, 32'h3000_0000, 1'b0, "R9 idle hold");
        send(1'b1, 4'd0, 32'h0000_8000, 3'b011, 32'h1000_0000, 32'h3000_0000, 1'b0, "R8 cause zero");
        send(1'b1, 4'd9, 32'h0000_8100, 3'b101, 32'h1000_0000, 32'h3000_0000, 1'b1, "R8 cause nine");
        send(1'b1, 4'd15, 32'h0000_8200, 3'b111, 32'h1000_0000, 32'h3000_0000, 1'b0, "R8 cause fifteen");
        send(1'b1, 4'd2, 32'h0000_8300, 3'b001, 32'h4000_0000, 32'h5000_0000, 1'b0, "R1 R9 back to back");
        send(1'b1, 4'd1, 32'h0000_8304, 3'b000, 32'h4000_0000, 32'h5000_0000, 1'b0, "R5 R9 back to back");
        send(1'b0, 4'd0, 32'h0, 3'b000, 32'h0, 32'h0, 1'b0, "R9 idle end");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule